// File: doc/BRIEF.md
# Word-Aligned Gray Fetch Address Counter

This block generates the program address for a word-oriented fetch path and presents it on the address lines in a split Gray encoding. The address is treated as two fields. The low field is the byte offset inside a word, and its width is log2 of the word size in bytes. The high field is the word index. Each field is Gray-coded on its own, and the two codes are placed side by side. A sequential fetch advances the word index by one. In this encoding that changes exactly one address line, which cuts switching on a heavily loaded address bus. Plain reflected Gray coding of the byte address would not give this when the step is 4 or 8.

A taken branch supplies a binary target through a strobe. The block converts the target field by field and loads it. If a branch and a sequential step arrive in the same cycle, the branch wins. A second output decodes the current Gray address back to binary, so that downstream logic and checkers can compare it against an ordinary byte address. The word size is fixed at elaboration to 4 or 8 bytes.

Top module: `gray_fetch_addr`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `addr_gray` and `addr_bin` are both zero.
- R2: When `step_en` is high and `jump_en` is low at a rising clock edge, `addr_bin` after that edge equals its earlier value plus WORD_BYTES, modulo 2^ADDR_W.
- R3: Every sequential step changes exactly one bit of `addr_gray`. This includes the step that wraps the word index from its maximum back to zero.
- R4: A sequential step leaves the low log2(WORD_BYTES) bits of `addr_gray` (the offset field) unchanged, even when the current address is not word-aligned.
- R5: When `jump_en` is high at a rising edge, `addr_bin` after that edge equals `jump_target` sampled at that edge, for any target, aligned or not.
- R6: When `jump_en` and `step_en` are both high at the same edge, the jump is taken and the step is ignored. `addr_bin` equals the target, not the target plus WORD_BYTES.
- R7: When neither `step_en` nor `jump_en` is high at an edge, `addr_gray` and `addr_bin` keep their values.
- R8: `addr_gray` equals {G(U), G(L)}, where L is the low log2(WORD_BYTES) bits of the binary address, U is the remaining upper bits, and G(x) = x ^ (x >> 1) is taken within each field's width. For example, with WORD_BYTES = 4 the binary address 8 is coded 1100, and with WORD_BYTES = 8 the binary address 4 is coded 0110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to address zero |
| step_en | input | 1 | Advance by one word at this edge |
| jump_en | input | 1 | Load `jump_target` at this edge; takes priority over `step_en` |
| jump_target | input | ADDR_W | Binary byte address of the branch target |
| addr_gray | output | ADDR_W | Current address in split Gray encoding |
| addr_bin | output | ADDR_W | Current address decoded back to binary |

## Verification
The bench builds two copies side by side, both with an 8-bit address. One uses 4-byte words and the other 8-byte words, so the 2-bit and 3-bit offset fields are checked against the same stimulus. The short address lets long runs of sequential steps wrap the word index in both copies, which covers the one-bit change at the wrap. Branch targets with nonzero offsets, including targets just below the top of the address space, show that the offset field survives later steps. Strobes that collide with steps in the same cycle cover the priority rule.

// File: rtl/gray_addr_pkg.sv
package gray_addr_pkg;

  // Width of the byte-offset field for a given word size in bytes.
  function automatic int offset_bits(input int word_bytes);
    int n;
    n = 0;
    while ((1 << n) < word_bytes) n++;
    return n;
  endfunction

endpackage

// File: rtl/gac_bin2gray.sv
module gac_bin2gray #(
  parameter int W = 4
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);

  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign gray_o = to_gray(bin_i);

endmodule

// File: rtl/gac_gray2bin.sv
module gac_gray2bin #(
  parameter int W = 4
) (
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);

  // Prefix XOR from the most significant bit down.
  assign bin_o[W-1] = gray_i[W-1];

  for (genvar i = W - 2; i >= 0; i--) begin : g_fold
    assign bin_o[i] = bin_o[i+1] ^ gray_i[i];
  end

endmodule

// File: rtl/gac_next.sv
module gac_next #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 2
) (
  input  logic [ADDR_W-1:0] cur_gray,
  input  logic              step_en,
  input  logic              jump_en,
  input  logic [ADDR_W-1:0] jump_target,
  output logic              jump_taken,
  output logic              step_taken,
  output logic [ADDR_W-1:0] nxt_gray
);

  localparam int UP_W = ADDR_W - OFF_W;

  logic [UP_W-1:0]  up_bin;
  logic [UP_W-1:0]  up_bin_inc;
  logic [UP_W-1:0]  up_gray_inc;
  logic [UP_W-1:0]  tgt_up_gray;
  logic [OFF_W-1:0] tgt_off_gray;

  // Gray-domain increment of the word index: decode, add one, encode.
  gac_gray2bin #(.W(UP_W)) u_up_dec (
    .gray_i (cur_gray[ADDR_W-1:OFF_W]),
    .bin_o  (up_bin)
  );

  assign up_bin_inc = up_bin + UP_W'(1);

  gac_bin2gray #(.W(UP_W)) u_up_enc (
    .bin_i  (up_bin_inc),
    .gray_o (up_gray_inc)
  );

  // Branch target loader: each field encoded separately.
  gac_bin2gray #(.W(UP_W)) u_tgt_up (
    .bin_i  (jump_target[ADDR_W-1:OFF_W]),
    .gray_o (tgt_up_gray)
  );

  gac_bin2gray #(.W(OFF_W)) u_tgt_off (
    .bin_i  (jump_target[OFF_W-1:0]),
    .gray_o (tgt_off_gray)
  );

  assign jump_taken = jump_en;
  assign step_taken = step_en && !jump_en;

  always_comb begin
    if (jump_taken)
      nxt_gray = {tgt_up_gray, tgt_off_gray};
    else if (step_taken)
      nxt_gray = {up_gray_inc, cur_gray[OFF_W-1:0]};
    else
      nxt_gray = cur_gray;
  end

endmodule

// File: rtl/gray_fetch_addr.sv
module gray_fetch_addr #(
  parameter int ADDR_W     = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              jump_en,
  input  logic [ADDR_W-1:0] jump_target,
  output logic [ADDR_W-1:0] addr_gray,
  output logic [ADDR_W-1:0] addr_bin
);

  localparam int OFF_W = gray_addr_pkg::offset_bits(WORD_BYTES);
  localparam int UP_W  = ADDR_W - OFF_W;

  if (WORD_BYTES != 4 && WORD_BYTES != 8) begin : g_bad_word
    $error("WORD_BYTES must be 4 or 8");
  end

  logic [ADDR_W-1:0] gray_q;
  logic [ADDR_W-1:0] gray_d;
  logic              jump_taken;
  logic              step_taken;

  gac_next #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_next (
    .cur_gray    (gray_q),
    .step_en     (step_en),
    .jump_en     (jump_en),
    .jump_target (jump_target),
    .jump_taken  (jump_taken),
    .step_taken  (step_taken),
    .nxt_gray    (gray_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= gray_d;
  end

  assign addr_gray = gray_q;

  // Read-back path: decode each field to binary.
  logic [UP_W-1:0]  rb_up;
  logic [OFF_W-1:0] rb_off;

  gac_gray2bin #(.W(UP_W)) u_rb_up (
    .gray_i (gray_q[ADDR_W-1:OFF_W]),
    .bin_o  (rb_up)
  );

  gac_gray2bin #(.W(OFF_W)) u_rb_off (
    .gray_i (gray_q[OFF_W-1:0]),
    .bin_o  (rb_off)
  );

  assign addr_bin = {rb_up, rb_off};

  // ---------------- assertions ----------------
  a_r2_step_adds_word: assert property (@(posedge clk) disable iff (!rst_n)
    step_taken |=> addr_bin == ADDR_W'($past(addr_bin) + ADDR_W'(WORD_BYTES)));

  a_r3_one_line_flips: assert property (@(posedge clk) disable iff (!rst_n)
    step_taken |=> $countones(addr_gray ^ $past(addr_gray)) == 1);

  a_r4_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    step_taken |=> addr_gray[OFF_W-1:0] == $past(addr_gray[OFF_W-1:0]));

  a_r5_jump_loads: assert property (@(posedge clk) disable iff (!rst_n)
    jump_en |=> addr_bin == $past(jump_target));

  a_r6_jump_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_en && step_en) |=> addr_bin == $past(jump_target));

  a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_en && !step_en) |=> $stable(addr_gray) && $stable(addr_bin));

  a_r8_taken_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({jump_taken, step_taken}));

endmodule

// File: tb/test_gray_fetch_addr.sv
module test_gray_fetch_addr;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step_en = 1'b0;
  logic          jump_en = 1'b0;
  logic [AW-1:0] jump_target = '0;
  logic [AW-1:0] g4, b4, g8, b8;

  always #10 clk = ~clk;  // 50 MHz

  gray_fetch_addr #(.ADDR_W(AW), .WORD_BYTES(4)) i_gray_fetch_addr (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .jump_en(jump_en),
    .jump_target(jump_target), .addr_gray(g4), .addr_bin(b4)
  );

  gray_fetch_addr #(.ADDR_W(AW), .WORD_BYTES(8)) i_gray_fetch_addr_w8 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .jump_en(jump_en),
    .jump_target(jump_target), .addr_gray(g8), .addr_bin(b8)
  );

  typedef struct {
    logic [AW-1:0] eb4;
    logic [AW-1:0] eb8;
    bit            is_step;
    string         tag;
  } exp_t;

  exp_t   sb[$];
  int     n_checks = 0;
  int     n_fail = 0;
  bit     done = 0;
  logic [AW-1:0] ref4 = '0, ref8 = '0;

  // Field-wise Gray code, built bit by bit: top bit of each field passes.
  function automatic logic [AW-1:0] enc(input logic [AW-1:0] b, input int ow);
    logic [AW-1:0] g;
    for (int i = 0; i < AW; i++)
      g[i] = (i == ow - 1 || i == AW - 1) ? b[i] : (b[i] ^ b[i+1]);
    return g;
  endfunction

  function automatic int ones(input logic [AW-1:0] v);
    int c = 0;
    for (int i = 0; i < AW; i++) c += v[i];
    return c;
  endfunction

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic drive(input bit st, input bit jp, input logic [AW-1:0] tgt, input string tag);
    exp_t e;
    @(negedge clk);
    step_en = st;
    jump_en = jp;
    jump_target = tgt;
    if (jp) begin
      ref4 = tgt; ref8 = tgt;
    end else if (st) begin
      ref4 = ref4 + AW'(4); ref8 = ref8 + AW'(8);
    end
    e.eb4 = ref4; e.eb8 = ref8; e.is_step = st && !jp; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: samples mid-high phase after each edge.
  logic [AW-1:0] prev4 = '0, prev8 = '0;
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({e.tag, " bin w4"}, b4, e.eb4);
      check({e.tag, " bin w8"}, b8, e.eb8);
      check("R8 gray w4", g4, enc(e.eb4, 2));
      check("R8 gray w8", g8, enc(e.eb8, 3));
      if (e.is_step) begin
        check("R3 flips w4", AW'(ones(g4 ^ prev4)), AW'(1));
        check("R3 flips w8", AW'(ones(g8 ^ prev8)), AW'(1));
        check("R4 offset w4", AW'(g4[1:0]), AW'(prev4[1:0]));
        check("R4 offset w8", AW'(g8[2:0]), AW'(prev8[2:0]));
      end
    end
    prev4 = g4;
    prev8 = g8;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #15;
    check("R1 reset gray w4", g4, '0);
    check("R1 reset bin w8", b8, '0);
    @(negedge clk);
    rst_n = 1'b1;
    #25;
    check("R1 released gray w8", g8, '0);
    check("R1 released bin w4", b4, '0);

    // R2/R3: long sequential run, wraps both word indices.
    for (int i = 0; i < 70; i++) drive(1, 0, '0, "R2 step");
    // R7: idle cycles
    for (int i = 0; i < 3; i++) drive(0, 0, 8'hA5, "R7 idle");
    // R5: misaligned jump, then steps keep the offset (R4)
    drive(0, 1, 8'h37, "R5 jump");
    for (int i = 0; i < 5; i++) drive(1, 0, '0, "R4 step after jump");
    // R6: collision of strobe and step
    drive(1, 1, 8'h52, "R6 jump wins");
    drive(1, 1, 8'h0B, "R6 jump wins");
    drive(0, 0, '0, "R7 idle");
    // Wrap near top with nonzero offset
    drive(0, 1, 8'hFD, "R5 jump top");
    for (int i = 0; i < 4; i++) drive(1, 0, '0, "R3 wrap step");
    // Mixed pattern
    for (int i = 0; i < 200; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 6)       drive(1, 0, '0, "R2 mix step");
      else if (r < 7)  drive(0, 0, AW'($urandom), "R7 mix idle");
      else if (r < 8)  drive(1, 1, AW'($urandom), "R6 mix both");
      else             drive(0, 1, AW'($urandom), "R5 mix jump");
    end
    drive(0, 0, '0, "R7 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule